// File: doc/BRIEF.md
# Command/Response Mailbox Controller

This block is a byte-wide, memory-mapped mailbox that sits behind a generic read/write bus, such as the back end of an I2C or SPI slave. A host writes a length-prefixed command packet into a 64-byte buffer through a window in a 16-bit address space. When the bus transaction ends, the block checks the packet's trailing 16-bit CRC. It then either hands the opcode and parameter fields to a downstream executor with a one-cycle strobe, or flags an error.

The executor sends its result back through a simple side port. It writes response bytes into the same buffer and then signals completion. The host reads the response from the window base. A write-any-value register rewinds the internal buffer pointer at any time, and a read-only status byte reports busy, response-ready and error.

All reads are combinational. The byte at the current pointer, the status byte, or 0xFF is presented in the same cycle that the address is on the bus. The pointer advances at the next clock edge.

Top module: `mbox_ctrl`

## Requirements
- R1: A read anywhere in 0xFE00..0xFFDF returns the buffer byte at the internal pointer. Each such read advances the pointer by one, and the pointer stays at 63 once it reaches 63.
- R2: A write of any data value to 0xFFE0 sets the pointer to 0 at the next edge, so the next window read returns byte 0.
- R3: A read of 0xFFF0 returns the status byte: bit 0 busy, bit 1 response ready, bit 2 error, bits 7..3 zero. A read of any other address outside the window returns 0xFF.
- R4: A write burst whose first window write is not at 0xFE00 stores nothing and is never dispatched. When it ends, the error bit is set.
- R5: The packet is big-endian: byte 0 count N, byte 1 opcode, byte 2 mode, bytes 3..4 param1, bytes 5..6 param2. The strobe presents these as cmd_count, cmd_opcode, cmd_mode, cmd_param1 and cmd_param2.
- R6: The CRC is CRC-16 with polynomial 0x8005 and initial value 0. It is processed most-significant bit first over bytes 0..N-3, with no reflection and no final XOR. It must equal {byte N-2, byte N-1}. A mismatch sets error and blocks dispatch.
- R7: A count below 7, a count above 64, or fewer than N bytes written before bus_end sets error and blocks dispatch.
- R8: When bus_end arrives after a good packet, cmd_valid is high for exactly the following cycle and busy is set.
- R9: While busy is set, window writes and bus_end change neither the buffer nor the status.
- R10: Bytes written past index N-1 of the packet are dropped, and the buffer keeps its earlier contents there.
- R11: rsp_we writes rsp_data into the buffer at rsp_idx. rsp_done while busy clears busy, sets response ready and returns the pointer to 0.
- R12: A first burst write at 0xFE00 while idle clears both error and response ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write request |
| bus_rd | input | 1 | Byte read request |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_end | input | 1 | Transaction end (stop), in a cycle with no write |
| bus_rdata | output | 8 | Read data, combinational |
| rsp_we | input | 1 | Executor buffer write |
| rsp_idx | input | 6 | Executor buffer index |
| rsp_data | input | 8 | Executor buffer data |
| rsp_done | input | 1 | Executor finished; response is in the buffer |
| cmd_valid | output | 1 | One-cycle dispatch strobe |
| cmd_count | output | 8 | Packet count byte |
| cmd_opcode | output | 8 | Opcode |
| cmd_mode | output | 8 | Mode byte |
| cmd_param1 | output | 16 | First parameter |
| cmd_param2 | output | 16 | Second parameter |

## Verification
Most faults in this block surface first as a wrong pointer, a stale CRC accumulator or a stuck status flag. A wrong pointer shows on the very next window read as a byte taken from a neighbouring index, or as a failure to stick at index 63. A stale CRC or a wrong count compare shows one cycle after bus_end, either as a missing or extra cmd_valid or as a status byte with the wrong error bit. Fields latched from the wrong bytes show on the strobe's own cycle. Ignored writes, during busy or from a misaligned burst, are exposed by reading the buffer back through the window after rewinding the pointer.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int BUF_DEPTH = 64;
    localparam int PTR_W     = $clog2(BUF_DEPTH);
    localparam int IDX_W     = PTR_W + 1;
    localparam int HDR_BYTES = 7;
    localparam int MIN_COUNT = 7;

    localparam logic [15:0] WIN_BASE     = 16'hFE00;
    localparam logic [15:0] WIN_LAST     = 16'hFFDF;
    localparam logic [15:0] PTR_CLR_ADDR = 16'hFFE0;
    localparam logic [15:0] STAT_ADDR    = 16'hFFF0;
    localparam logic [15:0] CRC_POLY     = 16'h8005;
    localparam logic [7:0]  IDLE_BYTE    = 8'hFF;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_WIN,
        RGN_PCLR,
        RGN_STAT
    } region_e;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       err;
        logic       rdy;
        logic       busy;
    } status_t;

    typedef struct packed {
        logic [7:0]  count;
        logic [7:0]  opcode;
        logic [7:0]  mode;
        logic [15:0] param1;
        logic [15:0] param2;
    } cmd_t;

    // One byte of CRC-16, most significant data bit first.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    // Next pointer value, holding at the last index.
    function automatic logic [PTR_W-1:0] ptr_adv(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(BUF_DEPTH - 1)) ? p : p + 1'b1;
    endfunction

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
(
    input  logic [15:0] addr,
    output region_e     rgn
);
    always_comb begin
        if (addr >= WIN_BASE && addr <= WIN_LAST) rgn = RGN_WIN;
        else if (addr == PTR_CLR_ADDR)            rgn = RGN_PCLR;
        else if (addr == STAT_ADDR)               rgn = RGN_STAT;
        else                                      rgn = RGN_NONE;
    end
endmodule

// File: rtl/mbox_crc_acc.sv
module mbox_crc_acc
    import mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst)      crc <= '0;
        else if (clr) crc <= en ? crc_step(16'h0000, din) : 16'h0000;
        else if (en)  crc <= crc_step(crc, din);
    end
endmodule

// File: rtl/mbox_store.sv
module mbox_store
    import mbox_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    parameter int AW    = $clog2(DEPTH),
    parameter int HDR   = HDR_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_idx,
    input  logic [7:0]       bus_d,
    input  logic             side_we,
    input  logic [AW-1:0]    side_idx,
    input  logic [7:0]       side_d,
    input  logic [AW-1:0]    rd_idx,
    output logic [7:0]       rd_d,
    output logic [HDR*8-1:0] hdr
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (bus_we) begin
            mem[bus_idx] <= bus_d;
        end else if (side_we) begin
            mem[side_idx] <= side_d;
        end
    end

    assign rd_d = mem[rd_idx];

    for (genvar g = 0; g < HDR; g++) begin : g_hdr
        assign hdr[g*8 +: 8] = mem[g];
    end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [15:0]      bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_end,
    output logic [7:0]       bus_rdata,
    input  logic             rsp_we,
    input  logic [PTR_W-1:0] rsp_idx,
    input  logic [7:0]       rsp_data,
    input  logic             rsp_done,
    output logic             cmd_valid,
    output logic [7:0]       cmd_count,
    output logic [7:0]       cmd_opcode,
    output logic [7:0]       cmd_mode,
    output logic [15:0]      cmd_param1,
    output logic [15:0]      cmd_param2
);
    region_e              rgn;
    logic [PTR_W-1:0]     ptr_q;
    logic [IDX_W-1:0]     wcnt_q;
    logic [7:0]           cnt_q;
    logic [15:0]          crc_rx_q;
    logic [15:0]          crc_calc;
    logic                 in_burst_q, burst_ok_q;
    logic                 busy_q, rdy_q, err_q;
    logic                 valid_q;
    cmd_t                 cmd_q;
    logic [7:0]           store_rd;
    logic [HDR_BYTES*8-1:0] hdr;

    logic             wr_win, first, start_ok, accept, crc_en, hi_cap, lo_cap;
    logic             end_evt, len_ok, good, done_evt;
    logic [IDX_W-1:0] idx;
    logic [7:0]       idx8, cnt_eff;
    status_t          stat;

    mbox_decode u_dec (.addr(bus_addr), .rgn(rgn));

    always_comb begin
        wr_win   = bus_wr && (rgn == RGN_WIN) && !busy_q;
        first    = wr_win && !in_burst_q;
        start_ok = first && (bus_addr == WIN_BASE);
        idx      = first ? '0 : wcnt_q;
        idx8     = 8'(idx);
        cnt_eff  = first ? bus_wdata : cnt_q;
        accept   = wr_win && (first ? start_ok : burst_ok_q)
                 && (idx8 < 8'(BUF_DEPTH)) && (first || idx8 < cnt_q);
        crc_en   = accept && (idx8 + 8'd2 < cnt_eff);
        hi_cap   = accept && (idx8 + 8'd2 == cnt_eff);
        lo_cap   = accept && (idx8 + 8'd1 == cnt_eff);
        end_evt  = bus_end && in_burst_q;
        len_ok   = (cnt_q >= 8'(MIN_COUNT)) && (cnt_q <= 8'(BUF_DEPTH))
                 && (8'(wcnt_q) == cnt_q);
        good     = end_evt && burst_ok_q && len_ok && (crc_calc == crc_rx_q);
        done_evt = rsp_done && busy_q;
    end

    mbox_crc_acc u_crc (
        .clk(clk), .rst(rst), .clr(start_ok), .en(crc_en),
        .din(bus_wdata), .crc(crc_calc)
    );

    mbox_store #(.DEPTH(BUF_DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .bus_we(accept), .bus_idx(idx[PTR_W-1:0]), .bus_d(bus_wdata),
        .side_we(rsp_we), .side_idx(rsp_idx), .side_d(rsp_data),
        .rd_idx(ptr_q), .rd_d(store_rd), .hdr(hdr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q      <= '0;
            wcnt_q     <= '0;
            cnt_q      <= '0;
            crc_rx_q   <= '0;
            in_burst_q <= 1'b0;
            burst_ok_q <= 1'b0;
            busy_q     <= 1'b0;
            rdy_q      <= 1'b0;
            err_q      <= 1'b0;
            valid_q    <= 1'b0;
            cmd_q      <= '0;
        end else begin
            valid_q <= good;
            if (good) begin
                busy_q <= 1'b1;
                cmd_q  <= '{count:  hdr[7:0],
                            opcode: hdr[15:8],
                            mode:   hdr[23:16],
                            param1: {hdr[31:24], hdr[39:32]},
                            param2: {hdr[47:40], hdr[55:48]}};
            end else if (end_evt) begin
                err_q <= 1'b1;
            end
            if (done_evt) begin
                busy_q <= 1'b0;
                rdy_q  <= 1'b1;
            end
            if (start_ok) begin
                err_q <= 1'b0;
                rdy_q <= 1'b0;
            end
            if (first) begin
                in_burst_q <= 1'b1;
                burst_ok_q <= start_ok;
            end else if (end_evt) begin
                in_burst_q <= 1'b0;
            end
            if (accept) wcnt_q <= idx + 1'b1;
            if (start_ok) cnt_q <= bus_wdata;
            if (hi_cap) crc_rx_q[15:8] <= bus_wdata;
            if (lo_cap) crc_rx_q[7:0]  <= bus_wdata;
            if (bus_wr && rgn == RGN_PCLR)       ptr_q <= '0;
            else if (done_evt)                   ptr_q <= '0;
            else if (accept)                     ptr_q <= ptr_adv(idx[PTR_W-1:0]);
            else if (bus_rd && rgn == RGN_WIN)   ptr_q <= ptr_adv(ptr_q);
        end
    end

    always_comb begin
        stat = '{rsvd: '0, err: err_q, rdy: rdy_q, busy: busy_q};
        unique case (rgn)
            RGN_WIN:  bus_rdata = store_rd;
            RGN_STAT: bus_rdata = stat;
            default:  bus_rdata = IDLE_BYTE;
        endcase
    end

    assign cmd_valid  = valid_q;
    assign cmd_count  = cmd_q.count;
    assign cmd_opcode = cmd_q.opcode;
    assign cmd_mode   = cmd_q.mode;
    assign cmd_param1 = cmd_q.param1;
    assign cmd_param2 = cmd_q.param2;
endmodule

// File: rtl/mbox_ctrl_chk.sv
module mbox_ctrl_chk
    import mbox_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [15:0]      bus_addr,
    input logic             bus_end,
    input logic [7:0]       bus_rdata,
    input logic             rsp_done,
    input logic             cmd_valid,
    input logic             busy,
    input logic             rdy,
    input logic             err,
    input logic             in_burst,
    input logic [PTR_W-1:0] ptr
);
    logic win_hit, rsvd_hit;
    assign win_hit  = bus_addr >= WIN_BASE && bus_addr <= WIN_LAST;
    assign rsvd_hit = (bus_addr > PTR_CLR_ADDR && bus_addr < STAT_ADDR) || bus_addr > STAT_ADDR;

    a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);
    a_r8_busy_with_strobe: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> busy);
    a_r8_after_end: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(bus_end));
    a_r2_rewind: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == PTR_CLR_ADDR) |=> ptr == '0);
    a_r1_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && win_hit && !bus_wr && !rsp_done && ptr == PTR_W'(BUF_DEPTH - 1))
        |=> ptr == PTR_W'(BUF_DEPTH - 1));
    a_r3_reserved_ff: assert property (@(posedge clk) disable iff (rst)
        rsvd_hit |-> bus_rdata == IDLE_BYTE);
    a_r11_done: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && busy) |=> (!busy && rdy));
    a_r12_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == WIN_BASE && !busy && !in_burst) |=> (!err && !rdy));
endmodule

bind mbox_ctrl mbox_ctrl_chk i_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_end(bus_end), .bus_rdata(bus_rdata), .rsp_done(rsp_done),
    .cmd_valid(cmd_valid), .busy(busy_q), .rdy(rdy_q), .err(err_q),
    .in_burst(in_burst_q), .ptr(ptr_q)
);

// File: tb/test_mbox_ctrl.sv
module test_mbox_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 0, bus_rd = 0, bus_end = 0;
    logic [15:0] bus_addr = 16'h0;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic        rsp_we = 0, rsp_done = 0;
    logic [5:0]  rsp_idx = 6'h0;
    logic [7:0]  rsp_data = 8'h0;
    logic        cmd_valid;
    logic [7:0]  cmd_count, cmd_opcode, cmd_mode;
    logic [15:0] cmd_param1, cmd_param2;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [7:0] pkt [80];
    logic [7:0] rb;
    logic       got_valid;

    always #2 clk = ~clk;

    mbox_ctrl i_mbox_ctrl (.*);

    // {count, opcode, mode, param1, corrupt crc, dispatch expected}
    localparam logic [41:0] VEC [7] = '{
        {8'd7,  8'hA1, 8'h00, 16'h1234, 1'b0, 1'b1},
        {8'd9,  8'h10, 8'h01, 16'hABCD, 1'b0, 1'b1},
        {8'd20, 8'h3C, 8'h7F, 16'h0F0F, 1'b0, 1'b1},
        {8'd64, 8'hE5, 8'h02, 16'hFFFF, 1'b0, 1'b1},
        {8'd9,  8'h22, 8'h05, 16'h1111, 1'b1, 1'b0},
        {8'd6,  8'h40, 8'h00, 16'h0000, 1'b0, 1'b0},
        {8'd65, 8'h41, 8'h00, 16'h0000, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'h0;
        for (int i = 0; i < n - 2; i++) begin
            c = c ^ {pkt[i], 8'h00};
            for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
        end
        return c;
    endfunction

    task automatic build(input logic [7:0] n, input logic [7:0] op, input logic [7:0] md,
                         input logic [15:0] p1, input logic flip);
        logic [15:0] c;
        pkt[0] = n; pkt[1] = op; pkt[2] = md; pkt[3] = p1[15:8]; pkt[4] = p1[7:0];
        for (int i = 5; i < 80; i++) pkt[i] = 8'(i * 13) + n;
        if (n >= 2 && n <= 64) begin
            c = ref_crc(int'(n));
            pkt[n-2] = c[15:8];
            pkt[n-1] = c[7:0] ^ {7'h0, flip};
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic send(input logic [15:0] start, input int n);
        for (int i = 0; i < n; i++) wr(start + 16'(i), pkt[i]);
    endtask

    // Pulse bus_end; cmd_valid is sampled in the cycle after the end edge.
    task automatic finish_burst();
        @(negedge clk); bus_end = 1;
        @(negedge clk); bus_end = 0;
        got_valid = cmd_valid;
    endtask

    task automatic done_pulse();
        @(negedge clk); rsp_done = 1;
        @(negedge clk); rsp_done = 0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // Reset state and address decode (R3)
        chk("R3 reset cmd_valid", cmd_valid, 0);
        rd(16'hFFF0, rb); chk("R3 reset status", rb, 8'h00);
        rd(16'hFFE5, rb); chk("R3 reserved FFE5", rb, 8'hFF);
        rd(16'hFFF7, rb); chk("R3 reserved FFF7", rb, 8'hFF);
        rd(16'h1234, rb); chk("R3 unmapped 1234", rb, 8'hFF);
        rd(16'hFFE0, rb); chk("R3 rewind reg read", rb, 8'hFF);

        // Fill the buffer through the side port (R11), then walk and saturate (R1)
        for (int i = 0; i < 64; i++) begin
            @(negedge clk); rsp_we = 1; rsp_idx = 6'(i); rsp_data = 8'(i) ^ 8'h5A;
        end
        @(negedge clk); rsp_we = 0;
        wr(16'hFFE0, 8'h00);
        for (int k = 0; k < 70; k++) begin
            rd(16'hFE00 + 16'(k), rb);
            chk($sformatf("R1 R11 read %0d", k), rb, 8'(k < 63 ? k : 63) ^ 8'h5A);
        end
        // Rewind with another data value (R2)
        wr(16'hFFE0, 8'hC3);
        rd(16'hFE00, rb); chk("R2 rewind byte0", rb, 8'h5A);
        rd(16'hFE00, rb); chk("R2 rewind byte1", rb, 8'h5B);

        // Trailing bytes past the count are dropped (R10)
        build(8'd7, 8'h99, 8'h03, 16'h4242, 1'b0);
        send(16'hFE00, 7);
        for (int i = 7; i < 10; i++) wr(16'hFE00 + 16'(i), 8'hEE);
        finish_burst();
        chk("R10 dispatch with trailing bytes", got_valid, 1);
        done_pulse();
        for (int i = 0; i < 10; i++) begin
            rd(16'hFE00, rb);
            chk($sformatf("R10 readback %0d", i), rb, i < 7 ? pkt[i] : 8'(i) ^ 8'h5A);
        end

        // Vector table: field extraction, CRC and length checks (R5 R6 R7 R8)
        for (int k = 0; k < 7; k++) begin
            logic [41:0] v;
            logic [7:0]  n;
            v = VEC[k];
            n = v[41:34];
            build(n, v[33:26], v[25:18], v[17:2], v[1]);
            send(16'hFE00, int'(n));
            finish_burst();
            chk($sformatf("R6 R7 R8 vec%0d dispatch", k), got_valid, v[0]);
            if (v[0]) begin
                chk($sformatf("R5 vec%0d count", k), cmd_count, n);
                chk($sformatf("R5 vec%0d opcode", k), cmd_opcode, v[33:26]);
                chk($sformatf("R5 vec%0d mode", k), cmd_mode, v[25:18]);
                chk($sformatf("R5 vec%0d param1", k), cmd_param1, v[17:2]);
                chk($sformatf("R5 vec%0d param2", k), cmd_param2, {pkt[5], pkt[6]});
            end
            @(negedge clk);
            chk($sformatf("R8 vec%0d strobe low", k), cmd_valid, 0);
            rd(16'hFFF0, rb);
            chk($sformatf("R8 R7 vec%0d status", k), rb, v[0] ? 8'h01 : 8'h04);
            if (v[0]) begin
                done_pulse();
                rd(16'hFFF0, rb); chk($sformatf("R11 vec%0d status", k), rb, 8'h02);
                rd(16'hFE00, rb); chk($sformatf("R11 vec%0d ptr base", k), rb, n);
            end
        end

        // Writes while busy are ignored (R9)
        build(8'd9, 8'h55, 8'h00, 16'h0102, 1'b0);
        send(16'hFE00, 9);
        finish_burst();
        chk("R9 setup dispatch", got_valid, 1);
        wr(16'hFE00, 8'h33);
        wr(16'hFE01, 8'h44);
        finish_burst();
        chk("R9 no dispatch while busy", got_valid, 0);
        rd(16'hFFF0, rb); chk("R9 status while busy", rb, 8'h01);
        done_pulse();
        rd(16'hFE00, rb); chk("R9 byte0 kept", rb, 8'd9);
        rd(16'hFE00, rb); chk("R9 byte1 kept", rb, 8'h55);

        // Misaligned start: nothing stored, error, no dispatch (R4)
        build(8'd9, 8'h77, 8'h00, 16'h0A0B, 1'b0);
        send(16'hFE01, 9);
        finish_burst();
        chk("R4 misaligned no dispatch", got_valid, 0);
        rd(16'hFFF0, rb); chk("R4 status error", rb, 8'h06);
        wr(16'hFFE0, 8'h01);
        rd(16'hFE00, rb); chk("R4 byte0 unchanged", rb, 8'd9);
        rd(16'hFE00, rb); chk("R4 byte1 unchanged", rb, 8'h55);

        // Valid start clears error and ready (R12), short burst then errors (R7)
        wr(16'hFE00, 8'd7);
        rd(16'hFFF0, rb); chk("R12 cleared on start", rb, 8'h00);
        finish_burst();
        chk("R7 short burst no dispatch", got_valid, 0);
        rd(16'hFFF0, rb); chk("R7 short burst error", rb, 8'h04);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule